// File: doc/BRIEF.md
# Quad-Channel Converter Serial Register Interface

This block is the serial-side front end of a four-channel output converter. A host drives 24-bit frames over a four-wire SPI link (clock idle low, data captured on the rising clock edge, slave output changed on the falling edge). The block oversamples the link on its own system clock, assembles each frame, and either updates its register file or latches a register value to return. Per channel it holds a data code, a gain word, an offset word, a slew configuration and a converter control word. Two configuration words are shared by all channels: a main word and a DC-DC word.

Every stored value, and a few decoded control bits, leave the block on plain parallel outputs for the converter datapath. Reads are split over two frames. The first frame names the register. During the second frame the slave shifts that value out while the host sends a harmless no-op word. The SPI link has no back-pressure: the host paces every transfer, and the register outputs are level signals that the datapath may sample at any time.

Top module: `quad_dac_spi_regs`

## Requirements
- R1: A frame is 24 bits, most significant bit first. Bit 23 is the read flag, bits 22:16 are the address and bits 15:0 are the payload. A frame takes effect only if exactly 24 rising clock edges arrived while chip select was low. Shorter and longer frames are dropped.
- R2: A write to address n (n = 0..3) loads the 16-bit data register of channel n. This value appears on `ch_data[16n+15:16n]`.
- R3: A write to address 0x08|n loads the gain of channel n. A write to 0x10|n loads the offset of channel n.
- R4: A write to 0x1C|n is a control write, and payload bits 15:13 select the target. Selector 0 stores the channel slew word, keeping bits 12 and 6:0 and clearing the rest. Selector 1 stores payload 12:0 into the shared main word. Selector 2 stores payload 8:0 into the channel converter control word. Selector 3 stores payload 6:0 into the shared DC-DC word. Selectors 4 to 7 change no register.
- R5: For each channel, `ch_range` carries bits 2:0 of the converter control word. `ch_dcdc_en` carries bit 4, `ch_out_en` carries bit 6 and `ch_int_en` carries bit 8.
- R6: Each committed read frame latches one 16-bit value. During the next frame, the slave drives that value on MISO in frame bits 15:0, with frame bits 23:16 driven zero.
- R7: Read addresses select registers as follows:
  - n: data of channel n
  - 0x04|n: converter control of channel n
  - 0x08|n: gain of channel n
  - 0x0C|n: offset of channel n
  - 0x14|n: slew of channel n
  - 0x19: main word
  - 0x1A: DC-DC word

  Narrower fields are zero-extended. A read frame never modifies a register.
- R8: Some frames return zero during the following frame:
  - a read of the clear-code addresses 0x10..0x13
  - a read of the status address 0x18
  - a read of any address above 0x1A
  - any committed non-read frame
- R9: After reset every register is zero except the four offsets, which are 0x8000. The first frame after reset returns zero.
- R10: A dropped frame changes no register and does not replace the value pending for return.
- R11: The no-op word 0x1CE000 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial link |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from host, idle low |
| cs_n | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial data to host, zero while deselected |
| ch_data | output | 64 | Data code of channels 3..0, 16 bits each |
| ch_gain | output | 64 | Gain words, 16 bits per channel |
| ch_offset | output | 64 | Offset words, 16 bits per channel |
| ch_slew | output | 52 | Slew words, 13 bits per channel |
| ch_dacctl | output | 36 | Converter control words, 9 bits per channel |
| ch_range | output | 12 | Output range code, 3 bits per channel |
| ch_out_en | output | 4 | Output enable per channel |
| ch_dcdc_en | output | 4 | DC-DC enable per channel |
| ch_int_en | output | 4 | Internal circuitry enable per channel |
| main_word | output | 13 | Shared main configuration word |
| dcdc_word | output | 7 | Shared DC-DC configuration word |

## Verification
The assertions watch the internal frame-commit strobe, so they rely on the host meeting the oversampling contract. Chip select may change only while the serial clock is low. Every clock level must last longer than the synchronizer depth plus one system cycle. MOSI must be stable well before each rising edge. The stimulus meets this by holding each serial clock phase for six system cycles and waiting eight cycles after selecting the slave before the first edge. It changes MOSI only while the serial clock is low.

// File: rtl/qdac_spi_pkg.sv
package qdac_spi_pkg;
  localparam int NCH        = 4;
  localparam int CH_W       = $clog2(NCH);
  localparam int FRAME_BITS = 24;
  localparam int WORD_W     = 16;
  localparam int ADDR_W     = 7;
  localparam int PAGE_W     = ADDR_W - CH_W;
  localparam int SLEW_W     = 13;
  localparam int DACCTL_W   = 9;
  localparam int MAIN_W     = 13;
  localparam int DCDC_W     = 7;
  localparam int SEL_W      = 3;

  localparam logic [WORD_W-1:0] OFFSET_RESET = 16'h8000;
  localparam logic [SLEW_W-1:0] SLEW_KEEP    = 13'h107F;

  // write pages (address bits above the channel index)
  localparam logic [PAGE_W-1:0] WPG_DATA = 5'h00;
  localparam logic [PAGE_W-1:0] WPG_GAIN = 5'h02;
  localparam logic [PAGE_W-1:0] WPG_OFFS = 5'h04;
  localparam logic [PAGE_W-1:0] WPG_CTRL = 5'h07;

  // read pages
  localparam logic [PAGE_W-1:0] RPG_DATA   = 5'h00;
  localparam logic [PAGE_W-1:0] RPG_DAC    = 5'h01;
  localparam logic [PAGE_W-1:0] RPG_GAIN   = 5'h02;
  localparam logic [PAGE_W-1:0] RPG_OFFS   = 5'h03;
  localparam logic [PAGE_W-1:0] RPG_SLEW   = 5'h05;
  localparam logic [PAGE_W-1:0] RPG_SHARED = 5'h06;

  typedef enum logic [SEL_W-1:0] {
    SUB_SLEW = 3'd0,
    SUB_MAIN = 3'd1,
    SUB_DAC  = 3'd2,
    SUB_DCDC = 3'd3,
    SUB_SOFT = 3'd4,
    SUB_RSV5 = 3'd5,
    SUB_RSV6 = 3'd6,
    SUB_RSV7 = 3'd7
  } ctl_sel_e;
endpackage

// File: rtl/qdac_spi_frame.sv
module qdac_spi_frame #(
  parameter int SYNC_STAGES = 2,
  parameter int FRAME_BITS  = 24,
  parameter int WORD_W      = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sclk,
  input  logic                  cs_n,
  input  logic                  mosi,
  output logic                  miso,
  input  logic [WORD_W-1:0]     tx_word,
  output logic                  frm_vld,
  output logic [FRAME_BITS-1:0] frm_word
);
  localparam int CNT_W = $clog2(FRAME_BITS + 2);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_OK  = CNT_W'(FRAME_BITS);

  logic sclk_s, cs_s, mosi_s;
  logic sclk_d, cs_d;

  generate
    if (SYNC_STAGES <= 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sclk_s <= 1'b0; cs_s <= 1'b1; mosi_s <= 1'b0;
        end else begin
          sclk_s <= sclk; cs_s <= cs_n; mosi_s <= mosi;
        end
      end
    end else begin : g_syncn
      logic [SYNC_STAGES-1:0] sclk_q, cs_q, mosi_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sclk_q <= '0; cs_q <= '1; mosi_q <= '0;
        end else begin
          sclk_q <= {sclk_q[SYNC_STAGES-2:0], sclk};
          cs_q   <= {cs_q[SYNC_STAGES-2:0], cs_n};
          mosi_q <= {mosi_q[SYNC_STAGES-2:0], mosi};
        end
      end
      assign sclk_s = sclk_q[SYNC_STAGES-1];
      assign cs_s   = cs_q[SYNC_STAGES-1];
      assign mosi_s = mosi_q[SYNC_STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0; cs_d <= 1'b1;
    end else begin
      sclk_d <= sclk_s; cs_d <= cs_s;
    end
  end

  logic rise, fall, start, stop;
  assign rise  = sclk_s & ~sclk_d & ~cs_s;
  assign fall  = ~sclk_s & sclk_d & ~cs_s;
  assign start = ~cs_s & cs_d;
  assign stop  = cs_s & ~cs_d;

  logic [CNT_W-1:0]      bit_cnt;
  logic [FRAME_BITS-1:0] rx_sh, tx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      rx_sh   <= '0;
      tx_sh   <= '0;
    end else if (start) begin
      bit_cnt <= '0;
      tx_sh   <= {{(FRAME_BITS-WORD_W){1'b0}}, tx_word};
    end else begin
      if (rise) begin
        rx_sh <= {rx_sh[FRAME_BITS-2:0], mosi_s};
        if (bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
      end
      if (fall) tx_sh <= {tx_sh[FRAME_BITS-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frm_vld  <= 1'b0;
      frm_word <= '0;
    end else begin
      frm_vld <= stop && (bit_cnt == CNT_OK);
      if (stop) frm_word <= rx_sh;
    end
  end

  assign miso = tx_sh[FRAME_BITS-1] & ~cs_s;
endmodule

// File: rtl/qdac_regfile.sv
module qdac_regfile
  import qdac_spi_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     frm_vld,
  input  logic [FRAME_BITS-1:0]    frm_word,
  output logic [WORD_W-1:0]        rd_pending,
  output logic [NCH*WORD_W-1:0]    ch_data,
  output logic [NCH*WORD_W-1:0]    ch_gain,
  output logic [NCH*WORD_W-1:0]    ch_offset,
  output logic [NCH*SLEW_W-1:0]    ch_slew,
  output logic [NCH*DACCTL_W-1:0]  ch_dacctl,
  output logic [NCH*3-1:0]         ch_range,
  output logic [NCH-1:0]           ch_out_en,
  output logic [NCH-1:0]           ch_dcdc_en,
  output logic [NCH-1:0]           ch_int_en,
  output logic [MAIN_W-1:0]        main_word,
  output logic [DCDC_W-1:0]        dcdc_word
);
  logic                is_rd;
  logic [ADDR_W-1:0]   addr;
  logic [PAGE_W-1:0]   page;
  logic [CH_W-1:0]     ch;
  logic [WORD_W-1:0]   pay;
  ctl_sel_e            sel;

  assign is_rd = frm_word[FRAME_BITS-1];
  assign addr  = frm_word[WORD_W +: ADDR_W];
  assign page  = addr[ADDR_W-1:CH_W];
  assign ch    = addr[CH_W-1:0];
  assign pay   = frm_word[WORD_W-1:0];
  assign sel   = ctl_sel_e'(pay[WORD_W-1 -: SEL_W]);

  logic wr_data, wr_gain, wr_offs, wr_ctrl;
  assign wr_data = frm_vld && !is_rd && page == WPG_DATA;
  assign wr_gain = frm_vld && !is_rd && page == WPG_GAIN;
  assign wr_offs = frm_vld && !is_rd && page == WPG_OFFS;
  assign wr_ctrl = frm_vld && !is_rd && page == WPG_CTRL;

  logic [WORD_W-1:0]   data_a [NCH];
  logic [WORD_W-1:0]   gain_a [NCH];
  logic [WORD_W-1:0]   offs_a [NCH];
  logic [SLEW_W-1:0]   slew_a [NCH];
  logic [DACCTL_W-1:0] dac_a  [NCH];

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic                hit;
    logic [WORD_W-1:0]   data_q, gain_q, offs_q;
    logic [SLEW_W-1:0]   slew_q;
    logic [DACCTL_W-1:0] dac_q;

    assign hit = (ch == CH_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        data_q <= '0;
        gain_q <= '0;
        offs_q <= OFFSET_RESET;
        slew_q <= '0;
        dac_q  <= '0;
      end else if (hit) begin
        if (wr_data) data_q <= pay;
        if (wr_gain) gain_q <= pay;
        if (wr_offs) offs_q <= pay;
        if (wr_ctrl && sel == SUB_SLEW) slew_q <= pay[SLEW_W-1:0] & SLEW_KEEP;
        if (wr_ctrl && sel == SUB_DAC)  dac_q  <= pay[DACCTL_W-1:0];
      end
    end

    assign data_a[g] = data_q;
    assign gain_a[g] = gain_q;
    assign offs_a[g] = offs_q;
    assign slew_a[g] = slew_q;
    assign dac_a[g]  = dac_q;

    assign ch_data[g*WORD_W +: WORD_W]       = data_q;
    assign ch_gain[g*WORD_W +: WORD_W]       = gain_q;
    assign ch_offset[g*WORD_W +: WORD_W]     = offs_q;
    assign ch_slew[g*SLEW_W +: SLEW_W]       = slew_q;
    assign ch_dacctl[g*DACCTL_W +: DACCTL_W] = dac_q;
    assign ch_range[g*3 +: 3]                = dac_q[2:0];
    assign ch_dcdc_en[g]                     = dac_q[4];
    assign ch_out_en[g]                      = dac_q[6];
    assign ch_int_en[g]                      = dac_q[8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      main_word <= '0;
      dcdc_word <= '0;
    end else if (wr_ctrl) begin
      if (sel == SUB_MAIN) main_word <= pay[MAIN_W-1:0];
      if (sel == SUB_DCDC) dcdc_word <= pay[DCDC_W-1:0];
    end
  end

  logic [WORD_W-1:0] rd_sel;
  always_comb begin
    rd_sel = '0;
    case (page)
      RPG_DATA:   rd_sel = data_a[ch];
      RPG_DAC:    rd_sel = WORD_W'(dac_a[ch]);
      RPG_GAIN:   rd_sel = gain_a[ch];
      RPG_OFFS:   rd_sel = offs_a[ch];
      RPG_SLEW:   rd_sel = WORD_W'(slew_a[ch]);
      RPG_SHARED: begin
        if (ch == CH_W'(1)) rd_sel = WORD_W'(main_word);
        else if (ch == CH_W'(2)) rd_sel = WORD_W'(dcdc_word);
      end
      default:    rd_sel = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_pending <= '0;
    else if (frm_vld) rd_pending <= is_rd ? rd_sel : '0;
  end
endmodule

// File: rtl/quad_dac_spi_regs.sv
module quad_dac_spi_regs
  import qdac_spi_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sclk,
  input  logic                     cs_n,
  input  logic                     mosi,
  output logic                     miso,
  output logic [NCH*WORD_W-1:0]    ch_data,
  output logic [NCH*WORD_W-1:0]    ch_gain,
  output logic [NCH*WORD_W-1:0]    ch_offset,
  output logic [NCH*SLEW_W-1:0]    ch_slew,
  output logic [NCH*DACCTL_W-1:0]  ch_dacctl,
  output logic [NCH*3-1:0]         ch_range,
  output logic [NCH-1:0]           ch_out_en,
  output logic [NCH-1:0]           ch_dcdc_en,
  output logic [NCH-1:0]           ch_int_en,
  output logic [MAIN_W-1:0]        main_word,
  output logic [DCDC_W-1:0]        dcdc_word
);
  logic                  frm_vld;
  logic [FRAME_BITS-1:0] frm_word;
  logic [WORD_W-1:0]     rd_pending;

  qdac_spi_frame #(
    .SYNC_STAGES(SYNC_STAGES),
    .FRAME_BITS (FRAME_BITS),
    .WORD_W     (WORD_W)
  ) u_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .sclk     (sclk),
    .cs_n     (cs_n),
    .mosi     (mosi),
    .miso     (miso),
    .tx_word  (rd_pending),
    .frm_vld  (frm_vld),
    .frm_word (frm_word)
  );

  qdac_regfile u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .frm_vld    (frm_vld),
    .frm_word   (frm_word),
    .rd_pending (rd_pending),
    .ch_data    (ch_data),
    .ch_gain    (ch_gain),
    .ch_offset  (ch_offset),
    .ch_slew    (ch_slew),
    .ch_dacctl  (ch_dacctl),
    .ch_range   (ch_range),
    .ch_out_en  (ch_out_en),
    .ch_dcdc_en (ch_dcdc_en),
    .ch_int_en  (ch_int_en),
    .main_word  (main_word),
    .dcdc_word  (dcdc_word)
  );
endmodule

// File: rtl/qdac_spi_checker.sv
module qdac_spi_checker
  import qdac_spi_pkg::*;
(
  input logic                     clk,
  input logic                     rst_n,
  input logic                     frm_vld,
  input logic [FRAME_BITS-1:0]    frm_word,
  input logic [NCH*WORD_W-1:0]    ch_data,
  input logic [NCH*WORD_W-1:0]    ch_gain,
  input logic [NCH*WORD_W-1:0]    ch_offset,
  input logic [NCH*SLEW_W-1:0]    ch_slew,
  input logic [NCH*DACCTL_W-1:0]  ch_dacctl,
  input logic [MAIN_W-1:0]        main_word,
  input logic [DCDC_W-1:0]        dcdc_word
);
  logic [3*NCH*WORD_W + NCH*SLEW_W + NCH*DACCTL_W + MAIN_W + DCDC_W - 1:0] all_regs;
  assign all_regs = {ch_data, ch_gain, ch_offset, ch_slew, ch_dacctl, main_word, dcdc_word};

  p_quiet_between_frames_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_vld |=> $stable(all_regs));

  p_read_keeps_regs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_vld && frm_word[23]) |=> $stable(all_regs));

  p_spare_selector_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_vld && !frm_word[23] && frm_word[22:18] == 5'b00111 && frm_word[15:13] >= 3'd4)
      |=> $stable(all_regs));

  p_noop_word_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_vld && frm_word == 24'h1CE000) |=> $stable(all_regs));

  p_data_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_vld && frm_word[23:16] == 8'h00) |=> ch_data[15:0] == $past(frm_word[15:0]));

  p_offset_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_vld && frm_word[23:16] == 8'h10) |=> ch_offset[15:0] == $past(frm_word[15:0]));

  p_reset_values_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (ch_offset == {NCH{OFFSET_RESET}} && ch_data == '0 && main_word == '0));
endmodule

bind quad_dac_spi_regs qdac_spi_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .frm_vld   (frm_vld),
  .frm_word  (frm_word),
  .ch_data   (ch_data),
  .ch_gain   (ch_gain),
  .ch_offset (ch_offset),
  .ch_slew   (ch_slew),
  .ch_dacctl (ch_dacctl),
  .main_word (main_word),
  .dcdc_word (dcdc_word)
);

// File: tb/quad_dac_spi_regs_test.sv
module quad_dac_spi_regs_test;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso;
  logic [63:0] ch_data, ch_gain, ch_offset;
  logic [51:0] ch_slew;
  logic [35:0] ch_dacctl;
  logic [11:0] ch_range;
  logic [3:0]  ch_out_en, ch_dcdc_en, ch_int_en;
  logic [12:0] main_word;
  logic [6:0]  dcdc_word;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [15:0] m_data [4];
  logic [15:0] m_gain [4];
  logic [15:0] m_offs [4];
  logic [12:0] m_slew [4];
  logic [8:0]  m_dac  [4];
  logic [12:0] m_main;
  logic [6:0]  m_dcdc;

  always #2 clk = ~clk;

  quad_dac_spi_regs uut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso),
    .ch_data(ch_data), .ch_gain(ch_gain), .ch_offset(ch_offset), .ch_slew(ch_slew),
    .ch_dacctl(ch_dacctl), .ch_range(ch_range), .ch_out_en(ch_out_en),
    .ch_dcdc_en(ch_dcdc_en), .ch_int_en(ch_int_en), .main_word(main_word),
    .dcdc_word(dcdc_word)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [23:0] w, input int nbits, output logic [23:0] r);
    r = '0;
    cs_n = 1'b0;
    repeat (8) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      mosi = (i < 24) ? w[23-i] : 1'b0;
      repeat (HALF) @(negedge clk);
      r = {r[22:0], miso};
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  task automatic wr(input logic [6:0] a, input logic [15:0] v);
    logic [23:0] r;
    xfer({1'b0, a, v}, 24, r);
  endtask

  task automatic ctl(input int n, input logic [2:0] sel, input logic [12:0] v);
    wr(7'h1C | 7'(n), {sel, v});
    case (sel)
      3'd0: m_slew[n] = v & 13'h107F;
      3'd1: m_main    = v;
      3'd2: m_dac[n]  = v[8:0];
      3'd3: m_dcdc    = v[6:0];
      default: ;
    endcase
  endtask

  function automatic logic [15:0] exp_rd(input int a);
    int n = a & 3;
    case (a >> 2)
      0: return m_data[n];
      1: return {7'b0, m_dac[n]};
      2: return m_gain[n];
      3: return m_offs[n];
      5: return {3'b0, m_slew[n]};
      6: return (a == 8'h19) ? {3'b0, m_main} : (a == 8'h1A) ? {9'b0, m_dcdc} : 16'h0;
      default: return 16'h0;
    endcase
  endfunction

  task automatic check_ports(input string req);
    for (int n = 0; n < 4; n++) begin
      chk({req, " R2 data"},   64'(ch_data[n*16 +: 16]),   64'(m_data[n]));
      chk({req, " R3 gain"},   64'(ch_gain[n*16 +: 16]),   64'(m_gain[n]));
      chk({req, " R3 offset"}, 64'(ch_offset[n*16 +: 16]), 64'(m_offs[n]));
      chk({req, " R4 slew"},   64'(ch_slew[n*13 +: 13]),   64'(m_slew[n]));
      chk({req, " R4 dacctl"}, 64'(ch_dacctl[n*9 +: 9]),   64'(m_dac[n]));
      chk({req, " R5 range"},  64'(ch_range[n*3 +: 3]),    64'(m_dac[n][2:0]));
      chk({req, " R5 enables"}, 64'({ch_int_en[n], ch_out_en[n], ch_dcdc_en[n]}),
          64'({m_dac[n][8], m_dac[n][6], m_dac[n][4]}));
    end
    chk({req, " R4 main"}, 64'(main_word), 64'(m_main));
    chk({req, " R4 dcdc"}, 64'(dcdc_word), 64'(m_dcdc));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [23:0] r, r2;
    for (int n = 0; n < 4; n++) begin
      m_data[n] = '0; m_gain[n] = '0; m_offs[n] = 16'h8000; m_slew[n] = '0; m_dac[n] = '0;
    end
    m_main = '0;
    m_dcdc = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R9: reset state and first returned frame
    check_ports("R9 reset");
    chk("R9 miso idle", 64'(miso), 64'h0);
    xfer(24'h1CE000, 24, r);
    chk("R9 first frame returns zero", 64'(r), 64'h0);

    // R1 R2 R3: data, gain and offset writes, MSB-first patterns
    for (int n = 0; n < 4; n++) begin
      m_data[n] = 16'hA5C3 ^ 16'(n * 16'h1357);
      m_gain[n] = 16'h8001 + 16'(n << 12);
      m_offs[n] = 16'h0F0F ^ 16'(n * 16'h2222);
      wr(7'(n), m_data[n]);
      wr(7'h08 | 7'(n), m_gain[n]);
      wr(7'h10 | 7'(n), m_offs[n]);
    end
    check_ports("R1 R2 R3 writes");

    // R4 R5: control sub-registers
    for (int n = 0; n < 4; n++) begin
      ctl(n, 3'd0, 13'h1FFF ^ 13'(n));
      ctl(n, 3'd2, 13'h1E00 | 13'(9'h151 + 9'(n * 37)));
    end
    ctl(1, 3'd1, 13'h1ABC);
    ctl(2, 3'd3, 13'h1FF5);
    check_ports("R4 R5 control");

    // R4: software and reserved selectors change nothing
    for (int s = 4; s < 8; s++) ctl(3, 3'(s), 13'h1FFF);
    check_ports("R4 spare selectors");

    // R11: the no-op word
    xfer(24'h1CE000, 24, r);
    check_ports("R11 noop");

    // R6 R7 R8: read every address
    for (int a = 0; a < 32; a++) begin
      xfer(24'h800000 | (24'(a) << 16), 24, r);
      xfer(24'h1CE000, 24, r);
      if (a >= 8'h1B || a == 8'h18 || (a >= 8'h10 && a <= 8'h13))
        chk($sformatf("R8 read addr %0h", a), 64'(r), 64'h0);
      else
        chk($sformatf("R7 R6 read addr %0h", a), 64'(r), 64'({8'h0, exp_rd(a)}));
    end
    check_ports("R7 reads keep registers");

    // R6: back-to-back reads return one frame late
    xfer(24'h800000, 24, r);
    xfer(24'h8B0000, 24, r);
    chk("R6 first of pair", 64'(r), 64'(m_data[0]));
    xfer(24'h1CE000, 24, r);
    chk("R6 second of pair", 64'(r), 64'(m_gain[3]));

    // R8: frame after a write returns zero
    m_data[1] = 16'h3C5A;
    wr(7'h01, m_data[1]);
    xfer(24'h1CE000, 24, r);
    chk("R8 after write", 64'(r), 64'h0);

    // R1 R10: short and long frames are dropped
    xfer({8'h00, 16'h1234}, 23, r);
    chk("R1 short frame dropped", 64'(ch_data[15:0]), 64'(m_data[0]));
    xfer({8'h00, 16'h4321}, 25, r);
    chk("R1 long frame dropped", 64'(ch_data[15:0]), 64'(m_data[0]));
    check_ports("R10 dropped frames");

    // R10: dropped frame keeps the pending read value
    xfer(24'h8C0000, 24, r);
    xfer(24'h800000, 20, r2);
    xfer(24'h1CE000, 24, r);
    chk("R10 pending kept", 64'(r), 64'(m_offs[0]));

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule